// File: doc/BRIEF.md
# Serial SAR converter sample sequencer

This block sits on the host side of a serial successive-approximation converter and runs one complete sample cycle per request. When a start request arrives while it is idle, it latches the channel number, the power mode and the input style (differential or single-ended). It then drives the conversion strobe low for a programmable acquisition time that never drops below the converter's minimum. Next it raises the strobe for the minimum conversion pulse and lowers it again to open the transfer window.

Inside that window it generates a serial clock. On this clock it shifts out a 16-bit control word, most significant bit first, and captures the 12-bit result, most significant bit first. It then watches the converter's data line. When that line goes low, the sample is complete: the block publishes the raw result and a 16-bit extended value, pulses done, and holds off new requests for a quiet period. If the data line never goes low, a timeout finishes the cycle with an error flag instead.

All converter timing minimums are given in nanoseconds and converted to cycle counts from the clock period parameter. The same source therefore fits different system clocks.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the outputs sit at: strobe high, serial clock high, serial data out low, busy, done and error low, result and value zero.
- R2: A start accepted while idle drives the strobe low for max(acq_cyc_i, ceil(400 ns / clock period)) cycles.
- R3: After acquisition the strobe is high for exactly ceil(100 ns / clock period) cycles and is then driven low.
- R4: The serial clock makes exactly 16 periods, each with high and low phases of HALF cycles, where HALF = max(SCLK_HALF_CYC, ceil(40 ns / clock period)). It toggles only while the strobe is low, and its first falling edge comes ceil(10 ns / clock period) + HALF cycles after the strobe falls for the transfer.
- R5: The control word goes out MSB first, one bit per serial clock falling edge, with the layout: bits 15:14 = 2'b11, bits 13:11 = channel, bits 10:9 = power mode, bits 8:0 = 0.
- R6: The first 12 data-out bits are sampled on serial clock rising edges, MSB first, and form the 12-bit result.
- R7: With the differential setting latched, value_o is the result sign-extended to 16 bits (bit 11 copied into bits 15:12). With the single-ended setting latched, bits 15:12 are zero.
- R8: After the transfer, data-out read low ends the cycle with a single-cycle done pulse, and result and value are updated at that moment.
- R9: If data-out stays high for TIMEOUT_CYC cycles after the transfer, done pulses with the error flag set and result and value keep their old contents. The error flag clears at the next accepted start.
- R10: Busy stays high from the accepted start until ceil(60 ns / clock period) cycles after done. A start seen while busy is ignored, and channel, mode and input style are taken only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one sample cycle |
| chan_i | input | 3 | Channel to select |
| pmode_i | input | 2 | Power mode field for the control word |
| diff_i | input | 1 | 1: differential (two's complement) result, 0: single-ended |
| acq_cyc_i | input | CNT_W | Requested acquisition length in cycles |
| sdo_i | input | 1 | Converter serial data out |
| conv_o | output | 1 | Conversion strobe |
| sclk_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Sample cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last cycle ended by timeout |
| result_o | output | 12 | Raw captured result |
| value_o | output | 16 | Extended result |

## Verification
The bench builds the block with a 20 ns clock period, a requested half period of 2 cycles and a 64-cycle timeout. This makes the acquisition floor 20 cycles, the strobe pulse 5 cycles, the clock-to-strobe gap 1 cycle and the quiet time 3 cycles. The short timeout makes the stuck-data-line path reachable within a few hundred cycles. The small minimums let a single trace cover a requested acquisition below the floor, one above it, and a start request that lands mid-cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int WORD_W = 16;
  localparam int RES_W  = 12;
  localparam int CHAN_W = 3;
  localparam int MODE_W = 2;
  localparam logic [1:0] LOAD_KEY = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_PULSE,
    ST_SETUP,
    ST_XFER,
    ST_WAIT,
    ST_QUIET
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_xfer.sv
module adc_seq_xfer #(
  parameter int WORD_W   = 16,
  parameter int RES_W    = 12,
  parameter int HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              fin_o,
  output logic [RES_W-1:0]  data_o
);

  localparam int IDX_W = $clog2(WORD_W) + 1;
  localparam int HC_W  = $clog2(HALF_CYC + 1);

  logic              active_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sclk_q, sdi_q, fin_q;
  logic [RES_W-1:0]  sh_q;
  logic              edge_w;

  assign edge_w = active_q && (hcnt_q == HC_W'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      idx_q    <= '0;
      sclk_q   <= 1'b1;
      sdi_q    <= 1'b0;
      fin_q    <= 1'b0;
      sh_q     <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        hcnt_q   <= '0;
        idx_q    <= '0;
        sclk_q   <= 1'b1;
      end else if (active_q) begin
        hcnt_q <= edge_w ? '0 : hcnt_q + 1'b1;
        if (edge_w) begin
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            // falling edge: present next control bit
            sdi_q <= word_i[WORD_W-1-int'(idx_q)];
          end else begin
            // rising edge: sample converter data
            if (idx_q < IDX_W'(RES_W)) sh_q <= {sh_q[RES_W-2:0], sdo_i};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(WORD_W - 1)) begin
              active_q <= 1'b0;
              fin_q    <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign sdi_o  = sdi_q;
  assign fin_o  = fin_q;
  assign data_o = sh_q;

endmodule

// File: rtl/adc_seq_ext.sv
module adc_seq_ext #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic             diff_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] value_o
);

  generate
    if (OUT_W > IN_W) begin : g_wide
      logic [OUT_W-IN_W-1:0] top_w;
      assign top_w   = diff_i ? {(OUT_W-IN_W){data_i[IN_W-1]}} : '0;
      assign value_o = {top_w, data_i};
    end else begin : g_same
      assign value_o = data_i[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SCLK_HALF_CYC = 4,
  parameter int CNT_W         = 16,
  parameter int TIMEOUT_CYC   = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        chan_i,
  input  logic [1:0]        pmode_i,
  input  logic              diff_i,
  input  logic [CNT_W-1:0]  acq_cyc_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [11:0]       result_o,
  output logic [15:0]       value_o
);

  localparam int ACQ_MIN_CYC = ceil_div(400, CLK_PERIOD_NS);
  localparam int PULSE_CYC   = max2(1, ceil_div(100, CLK_PERIOD_NS));
  localparam int CSDLY_CYC   = max2(1, ceil_div(10, CLK_PERIOD_NS));
  localparam int QUIET_CYC   = max2(1, ceil_div(60, CLK_PERIOD_NS));
  localparam int HALF_CYC    = max2(max2(SCLK_HALF_CYC, 1),
                                    max2(ceil_div(40, CLK_PERIOD_NS),
                                         ceil_div(30, CLK_PERIOD_NS)));

  seq_state_e          state_q, state_d;
  logic [WORD_W-1:0]   word_q;
  logic                diff_q;
  logic [RES_W-1:0]    result_q;
  logic [15:0]         value_q;
  logic                done_q, err_q;

  logic                ld_w, zero_w, go_w, fin_w, accept_w, eoc_w, tmo_w;
  logic [CNT_W-1:0]    ld_val_w, acq_len_w;
  logic [RES_W-1:0]    xfer_data_w;
  logic [15:0]         ext_w;

  assign acq_len_w = (acq_cyc_i < CNT_W'(ACQ_MIN_CYC)) ? CNT_W'(ACQ_MIN_CYC) : acq_cyc_i;

  always_comb begin
    state_d  = state_q;
    ld_w     = 1'b0;
    ld_val_w = '0;
    go_w     = 1'b0;
    accept_w = 1'b0;
    eoc_w    = 1'b0;
    tmo_w    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_ACQ;
        ld_w     = 1'b1;
        ld_val_w = acq_len_w - 1'b1;
        accept_w = 1'b1;
      end
      ST_ACQ: if (zero_w) begin
        state_d  = ST_PULSE;
        ld_w     = 1'b1;
        ld_val_w = CNT_W'(PULSE_CYC - 1);
      end
      ST_PULSE: if (zero_w) begin
        state_d  = ST_SETUP;
        ld_w     = 1'b1;
        ld_val_w = CNT_W'(CSDLY_CYC - 1);
      end
      ST_SETUP: if (zero_w) begin
        state_d = ST_XFER;
        go_w    = 1'b1;
      end
      ST_XFER: if (fin_w) begin
        state_d  = ST_WAIT;
        ld_w     = 1'b1;
        ld_val_w = CNT_W'(TIMEOUT_CYC - 1);
      end
      ST_WAIT: if (!sdo_i || zero_w) begin
        state_d  = ST_QUIET;
        ld_w     = 1'b1;
        ld_val_w = CNT_W'(QUIET_CYC - 1);
        eoc_w    = !sdo_i;
        tmo_w    = sdo_i;
      end
      ST_QUIET: if (zero_w) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      diff_q   <= 1'b0;
      result_q <= '0;
      value_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= eoc_w | tmo_w;
      if (accept_w) begin
        word_q <= {LOAD_KEY, chan_i, pmode_i, {(WORD_W-CHAN_W-MODE_W-2){1'b0}}};
        diff_q <= diff_i;
        err_q  <= 1'b0;
      end
      if (eoc_w) begin
        result_q <= xfer_data_w;
        value_q  <= ext_w;
      end
      if (tmo_w) err_q <= 1'b1;
    end
  end

  adc_seq_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_w),
    .val_i  (ld_val_w),
    .zero_o (zero_w)
  );

  adc_seq_xfer #(.WORD_W(WORD_W), .RES_W(RES_W), .HALF_CYC(HALF_CYC)) i_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_w),
    .word_i (word_q),
    .sdo_i  (sdo_i),
    .sclk_o (sclk_o),
    .sdi_o  (sdi_o),
    .fin_o  (fin_w),
    .data_o (xfer_data_w)
  );

  adc_seq_ext #(.IN_W(RES_W), .OUT_W(16)) i_ext (
    .diff_i  (diff_q),
    .data_i  (xfer_data_w),
    .value_o (ext_w)
  );

  assign conv_o   = (state_q == ST_IDLE) || (state_q == ST_PULSE) || (state_q == ST_QUIET);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = result_q;
  assign value_o  = value_q;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ACQ_MIN   = 40,
  parameter int PULSE_MIN = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  logic [15:0] lo_run_q, hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= '0;
    end else begin
      lo_run_q <= conv_o ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !conv_o ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  AST_ACQ_LONG_ENOUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(conv_o) && !done_o) |-> (lo_run_q >= 16'(ACQ_MIN))); // R2
  AST_PULSE_WIDE_ENOUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $fell(conv_o)) |-> (hi_run_q >= 16'(PULSE_MIN))); // R3
  AST_SCLK_ONLY_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> sclk_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10

endmodule

bind adc_seq_ctrl adc_seq_chk #(.ACQ_MIN(ACQ_MIN_CYC), .PULSE_MIN(PULSE_CYC)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .conv_o (conv_o),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int CLK_NS  = 20;
  localparam int HALF    = 2;
  localparam int TMO     = 64;
  localparam int ACQ_MIN = 20;
  localparam int PULSE   = 5;
  localparam int CSDLY   = 1;
  localparam int QUIET   = 3;
  localparam int TRACE_N = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  chan = '0;
  logic [1:0]  pmode = '0;
  logic        diff = 1'b0;
  logic [15:0] acq = '0;
  logic        sdo;
  logic        conv, sclk, sdi, busy, done, err;
  logic [11:0] result;
  logic [15:0] value;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // converter model
  logic [11:0] m_res = '0;
  logic [15:0] m_word = '0;
  int          fall_k = 0;
  int          rise_k = 0;
  logic        bit_val = 1'b1;
  logic        eoc = 1'b0;
  logic        hang = 1'b0;

  logic [11:0] prev_res = '0;
  logic [15:0] prev_val = '0;

  bit tc [TRACE_N];
  bit ts [TRACE_N];
  bit td [TRACE_N];

  assign sdo = eoc ? 1'b0 : bit_val;

  always #(CLK_NS/2) clk = ~clk;

  adc_seq_ctrl #(
    .CLK_PERIOD_NS(CLK_NS), .SCLK_HALF_CYC(HALF), .CNT_W(16), .TIMEOUT_CYC(TMO)
  ) i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .pmode_i(pmode),
    .diff_i(diff), .acq_cyc_i(acq), .sdo_i(sdo), .conv_o(conv), .sclk_o(sclk),
    .sdi_o(sdi), .busy_o(busy), .done_o(done), .err_o(err), .result_o(result),
    .value_o(value)
  );

  always @(negedge sclk) begin
    if (fall_k < 12) bit_val = m_res[11-fall_k];
    else             bit_val = 1'b1;
    fall_k++;
  end

  always @(posedge sclk) begin
    m_word = {m_word[14:0], sdi};
    rise_k++;
    if (rise_k == 16 && !hang) begin
      repeat (3) @(posedge clk);
      eoc = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ext(input logic [11:0] r, input logic d);
    return d ? {{4{r[11]}}, r} : {4'b0, r};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "conv", conv, 1'b1);
    chk("R1", "sclk", sclk, 1'b1);
    chk("R1", "sdi", sdi, 1'b0);
    chk("R1", "busy/done/err", {busy, done, err}, 3'b000);
    chk("R1", "result/value", {result, value}, 28'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after release", {conv, busy}, 2'b10);
  endtask

  task automatic t_sample(input int acq_req, input logic [2:0] ch, input logic [1:0] md,
                          input logic df, input logic [11:0] res, input logic hg,
                          input logic poke, input string tag);
    int n, a, b, s0, f, last, falls, bad, dcount, didx, badwin;
    @(negedge clk);
    acq = 16'(acq_req); chan = ch; pmode = md; diff = df;
    m_res = res; m_word = '0; fall_k = 0; rise_k = 0; bit_val = 1'b1; eoc = 1'b0; hang = hg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < TRACE_N) begin
      tc[n] = conv; ts[n] = sclk; td[n] = done;
      if (!busy) break;
      if (poke && n == 30) begin start = 1'b1; chan = ch ^ 3'b101; pmode = ~md; diff = ~df; end
      if (poke && n == 31) begin start = 1'b0; chan = ch; pmode = md; diff = df; end
      n++;
      @(negedge clk);
    end
    a = 0;
    while (a < n && tc[a] == 1'b0) a++;
    chk("R2", {tag, " acquisition cycles"}, a, (acq_req > ACQ_MIN) ? acq_req : ACQ_MIN);
    b = 0;
    while (a + b < n && tc[a+b] == 1'b1) b++;
    chk("R3", {tag, " strobe pulse cycles"}, b, PULSE);
    s0 = a + b;
    f = s0;
    while (f < n && ts[f] == 1'b1) f++;
    chk("R4", {tag, " first sclk fall delay"}, f - s0, CSDLY + HALF);
    falls = 1; bad = 0; last = f; badwin = 0;
    for (int k = f + 1; k <= n; k++) begin
      if (ts[k] != ts[k-1]) begin
        if (k - last != HALF) bad++;
        if (ts[k] == 1'b0) falls++;
        last = k;
      end
    end
    for (int k = 0; k <= n; k++) if (tc[k] && !ts[k]) badwin++;
    chk("R4", {tag, " sclk falls"}, falls, 16);
    chk("R4", {tag, " sclk phase errors"}, bad, 0);
    chk("R4", {tag, " sclk low with strobe high"}, badwin, 0);
    chk("R5", {tag, " control word"}, m_word, {2'b11, ch, md, 9'b0});
    dcount = 0; didx = 0;
    for (int k = 0; k <= n; k++) if (td[k]) begin dcount++; didx = k; end
    chk("R8", {tag, " done pulses"}, dcount, 1);
    chk("R10", {tag, " quiet after done"}, n - didx, QUIET);
    if (hg) begin
      chk("R9", {tag, " error flag"}, err, 1'b1);
      chk("R9", {tag, " result kept"}, result, prev_res);
      chk("R9", {tag, " value kept"}, value, prev_val);
    end else begin
      chk("R9", {tag, " error clear"}, err, 1'b0);
      chk("R6", {tag, " result"}, result, res);
      chk("R7", {tag, " value"}, value, ext(res, df));
      prev_res = res;
      prev_val = ext(res, df);
    end
    if (poke) begin
      badwin = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!conv || busy) badwin++;
      end
      chk("R10", {tag, " start while busy ignored"}, badwin, 0);
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sample(30, 3'd5, 2'b01, 1'b0, 12'hA5C, 1'b0, 1'b0, "se_long");
    t_sample(4,  3'd2, 2'b10, 1'b1, 12'h800, 1'b0, 1'b0, "diff_short");
    t_sample(25, 3'd7, 2'b00, 1'b1, 12'h7FF, 1'b0, 1'b1, "diff_poke");
    t_sample(20, 3'd1, 2'b01, 1'b1, 12'h123, 1'b1, 1'b0, "timeout");
    t_sample(20, 3'd0, 2'b11, 1'b0, 12'hFFF, 1'b0, 1'b0, "se_full");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule